// File: doc/BRIEF.md
# Tone Frequency Discriminator by Toggle Parity

This block tells a slow square-wave tone from a fast one using a system clock that runs thousands of times faster than either tone. With the default parameters the clock is 6 MHz and the tones are 1 kHz (3000 clock cycles per half period) and 10 kHz (300 cycles per half period). The single output `class_hi` settles to 0 for the slow tone and to 1 for the fast tone. It follows a change of tone by itself.

The raw tone is sampled once by a clock register. A delay stage then reshapes the sampled tone. Its falling edges pass after a fixed latency. Its rising edges are held back by a down-counter whose load value depends on the present output. A toggle flop flips on every cycle in which the delayed tone is high. When the delayed tone falls, the toggle value is copied into the output flop. The output therefore changes state exactly when an odd number of cycles was enabled.

The delay values are chosen so that a wrong output sees an odd count and corrects itself, while a correct output sees an even count and stays. When the output is high, a high phase shorter than the delay is swallowed and enables zero cycles. When the output is low, a delayed rise is always launched, and a phase that ends before the launch enables exactly one cycle. The user gives an asynchronous active-low reset. Its release is synchronised inside the block.

Top module: `tone_discrim`

## Requirements
- R1: While `rst_n` is low, `class_hi` is 0 and the delay and toggle state are cleared. The release of `rst_n` takes effect synchronously, and `class_hi` stays 0 afterwards until a high phase of the tone completes.
- R2: `class_hi` changes only on the second clock edge after the delayed tone falls. While the tone stays low, `class_hi` keeps its value.
- R3: When `class_hi` is 1, a sampled high phase of H cycles enables H - DLY_CLASS_HI cycles if H > DLY_CLASS_HI, and zero cycles otherwise. The boundary case H = DLY_CLASS_HI is swallowed.
- R4: When `class_hi` is 0, a sampled high phase of H cycles enables H - DLY_CLASS_LO cycles if H > DLY_CLASS_LO, and exactly one cycle otherwise. The single cycle is launched DLY_CLASS_LO cycles after the sampled rise. This needs a following low phase of at least DLY_CLASS_LO - H + 3 cycles.
- R5: At the end of each high phase, `class_hi` inverts if the number of enabled cycles was odd, and holds if it was even.
- R6: For a 1 kHz tone (3000-cycle halves), `class_hi` is 0. For a 10 kHz tone (300-cycle halves), it is 1. Both hold from the end of the first complete high phase of that tone, whatever the earlier class, and at any phase of the tone relative to the clock.
- R7: Start with `class_hi` at 0 and apply a single 300-cycle pulse. Count the first rising clock edge after the tone rises as edge 1. Then `class_hi` is still 0 after edge DLY_CLASS_LO + 3 and becomes 1 on edge DLY_CLASS_LO + 4.
- R8: If the tone falls while the delayed tone is high, the delayed tone is low on the next cycle. This is the fixed falling-edge latency.
- R9: The toggle flop holds its value in every cycle in which the delayed tone is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (6 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_in | input | 1 | Raw tone, asynchronous to `clk` |
| class_hi | output | 1 | 0 = slow tone (1 kHz), 1 = fast tone (10 kHz) |

## Verification
The bench goes after the boundary pulse lengths of the delay stage, which a purely random run would not reach. One is a pulse exactly as long as the output-high delay. A counter that resolved the tie between its own expiry and the input's fall the wrong way would pass one enabled cycle and flip the output. Another is a pulse shorter than the output-low delay. A design that swallowed it would stay low on the fast tone forever. The exact cycle of the first output rise is measured, which catches an extra or missing register anywhere on the path. Random-phase tone segments and mid-run switches are checked against a bench model of the parity rules, and an asynchronous reset with the output high checks that it clears at once.

// File: rtl/tdisc_pkg.sv
package tdisc_pkg;

  // States of the edge-delay stage. The delayed tone is high in ST_HIGH and ST_PULSE.
  typedef enum logic [2:0] {
    ST_IDLE,      // delayed tone low, waiting for a sampled rise
    ST_ARM,       // counting down the rise delay, sampled tone still high
    ST_ARM_LATE,  // committed launch, sampled tone already low
    ST_HIGH,      // delayed tone follows the sampled high phase
    ST_PULSE      // single enabled cycle for a phase shorter than the delay
  } dly_state_e;

  // Counter width that holds (max_delay - 1)
  function automatic int unsigned delay_cnt_width(input int unsigned a, input int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/tdisc_rst_sync.sv
module tdisc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  generate
    if (STAGES == 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q <= 1'b0;
        else          sync_q <= 1'b1;
      end
      assign rst_no = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      logic [STAGES-1:0] sync_d;
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sync_q <= '0;
        else          sync_q <= sync_d;
      end
      assign rst_no = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/tdisc_sampler.sv
module tdisc_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tone_i,
  output logic rise_o,
  output logic fall_o
);

  // The only flop allowed to see a setup violation: tone_i is asynchronous.
  logic smp_q, smp_d;
  logic prev_q, prev_d;

  always_comb begin
    smp_d  = tone_i;
    prev_d = smp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o =  smp_q & ~prev_q;
  assign fall_o = ~smp_q &  prev_q;

endmodule

// File: rtl/tdisc_edge_delay.sv
module tdisc_edge_delay
  import tdisc_pkg::*;
#(
  parameter int unsigned DLY_CLASS_LO = 450,
  parameter int unsigned DLY_CLASS_HI = 1499,
  parameter int unsigned CNT_W        = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic class_i,
  output logic dly_o
);

  localparam logic [CNT_W-1:0] LOAD_LO = CNT_W'(DLY_CLASS_LO - 1);
  localparam logic [CNT_W-1:0] LOAD_HI = CNT_W'(DLY_CLASS_HI - 1);

  dly_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // Next-state logic. Output high: qualify mode (a fall before expiry aborts).
  // Output low: commit mode (the launch always happens).
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rise_i) begin
          state_d = ST_ARM;
          cnt_d   = class_i ? LOAD_HI : LOAD_LO;
          cnt_en  = 1'b1;
        end
      end
      ST_ARM: begin
        if (fall_i) begin
          if (class_i) begin
            state_d = ST_IDLE;
          end else if (cnt_zero) begin
            state_d = ST_PULSE;
          end else begin
            state_d = ST_ARM_LATE;
            cnt_d   = cnt_q - 1'b1;
            cnt_en  = 1'b1;
          end
        end else if (cnt_zero) begin
          state_d = ST_HIGH;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_ARM_LATE: begin
        if (cnt_zero) begin
          state_d = ST_PULSE;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_HIGH: begin
        if (fall_i) state_d = ST_IDLE;
      end
      ST_PULSE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign dly_o = (state_q == ST_HIGH) || (state_q == ST_PULSE);

  // R8: fixed falling latency, one cycle from the sampled fall
  a_r8_fall_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && dly_o) |=> !dly_o);

  // R3: in qualify mode a fall before the delayed rise keeps the phase swallowed
  a_r3_qualify_swallow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !dly_o && class_i) |=> !dly_o);

endmodule

// File: rtl/tdisc_parity_hold.sv
module tdisc_parity_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dly_i,
  output logic class_o
);

  logic tog_q, tog_d, tog_en;
  logic dlyp_q;
  logic class_q, class_d, class_en;

  always_comb begin
    tog_en   = dly_i;
    tog_d    = ~tog_q;
    class_en = dlyp_q & ~dly_i;   // delayed tone seen falling
    class_d  = tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q   <= 1'b0;
      dlyp_q  <= 1'b0;
      class_q <= 1'b0;
    end else begin
      dlyp_q <= dly_i;
      if (tog_en)   tog_q   <= tog_d;
      if (class_en) class_q <= class_d;
    end
  end

  assign class_o = class_q;

  // R2: the class moves only on the edge after a detected delayed fall
  a_r2_class_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(class_q) |-> $past(dlyp_q && !dly_i));

  // R9: toggle frozen while the delayed tone is low
  a_r9_toggle_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dly_i |=> $stable(tog_q));

endmodule

// File: rtl/tone_discrim.sv
module tone_discrim
  import tdisc_pkg::*;
#(
  parameter int unsigned DLY_CLASS_LO = 450,
  parameter int unsigned DLY_CLASS_HI = 1499,
  parameter int unsigned RST_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_in,
  output logic class_hi
);

  localparam int unsigned CNT_W = delay_cnt_width(DLY_CLASS_LO, DLY_CLASS_HI);

  logic rst_sync_n;
  logic smp_rise, smp_fall;
  logic dly_tone;
  logic class_q;

  tdisc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i  (clk),
    .arst_ni(rst_n),
    .rst_no (rst_sync_n)
  );

  tdisc_sampler u_smp (
    .clk_i (clk),
    .rst_ni(rst_sync_n),
    .tone_i(tone_in),
    .rise_o(smp_rise),
    .fall_o(smp_fall)
  );

  tdisc_edge_delay #(
    .DLY_CLASS_LO(DLY_CLASS_LO),
    .DLY_CLASS_HI(DLY_CLASS_HI),
    .CNT_W       (CNT_W)
  ) u_dly (
    .clk_i  (clk),
    .rst_ni (rst_sync_n),
    .rise_i (smp_rise),
    .fall_i (smp_fall),
    .class_i(class_q),
    .dly_o  (dly_tone)
  );

  tdisc_parity_hold u_par (
    .clk_i  (clk),
    .rst_ni (rst_sync_n),
    .dly_i  (dly_tone),
    .class_o(class_q)
  );

  assign class_hi = class_q;

  // R1: output cleared whenever the internal reset is active
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      a_r1_reset_clear: assert (class_hi == 1'b0);
    end
  end

endmodule

// File: tb/tone_discrim_tb.sv
`timescale 1ns/1ps
module tone_discrim_tb_top;

  localparam int D_LO  = 450;
  localparam int D_HI  = 1499;
  localparam int H_1K  = 3000;
  localparam int H_10K = 300;
  localparam int WATCHDOG = 190000;

  logic clk;
  logic rst_n;
  logic tone_in;
  logic class_hi;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cyc    = 0;
  bit  model;

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  tone_discrim #(
    .DLY_CLASS_LO(D_LO),
    .DLY_CLASS_HI(D_HI),
    .RST_STAGES  (2)
  ) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tone_in (tone_in),
    .class_hi(class_hi)
  );

  // Enabled cycles for one high phase (R3, R4)
  function automatic int enabled_cycles(input int h, input bit cls);
    if (cls) return (h > D_HI) ? h - D_HI : 0;
    else     return (h > D_LO) ? h - D_LO : 1;
  endfunction

  // Parity rule (R5)
  function automatic bit next_class(input int h, input bit cls);
    int e;
    e = enabled_cycles(h, cls);
    return cls ^ ((e % 2) == 1);
  endfunction

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic check(input bit exp, input string req);
    n_chk++;
    if (class_hi !== exp) begin
      n_fail++;
      $display("FAIL %s: class_hi=%0b expected %0b at %0t", req, class_hi, exp, $time);
    end
  endtask

  // Place the next tone edge at a random point well away from a clock edge
  task automatic align();
    @(posedge clk);
    #(real'(300 + $urandom_range(1400)) / 1000.0);
  endtask

  task automatic high_phase(input int h);
    tone_in = 1'b1;
    #(h * 4);
    tone_in = 1'b0;
    model = next_class(h, model);
  endtask

  task automatic pulse(input int h, input int low, input string req);
    align();
    high_phase(h);
    #(low * 4);
    check(model, req);
  endtask

  task automatic run_tone(input int h, input int periods, input string req);
    align();
    repeat (periods) begin
      high_phase(h);
      #(h * 4);
      check(model, req);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): cycles=%0d expected < %0d", cyc, WATCHDOG);
      report_end();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    rst_n   = 1'b0;
    tone_in = 1'b0;
    model   = 1'b0;

    // R1: reset state
    repeat (5) @(posedge clk);
    #1;
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    check(1'b0, "R1 after release");

    // R2: no activity, no change
    repeat (500) @(posedge clk);
    #1;
    check(1'b0, "R2 idle low");

    // R7: exact cycle of the first output rise (also R4 single launched cycle)
    align();
    tone_in = 1'b1;
    fork
      begin
        #(H_10K * 4);
        tone_in = 1'b0;
      end
      begin
        repeat (D_LO + 3) @(posedge clk);
        #1;
        check(1'b0, "R7 before edge D_LO+4");
        @(posedge clk);
        #1;
        check(1'b1, "R7 at edge D_LO+4");
      end
    join
    model = next_class(H_10K, 1'b0);
    repeat (2000) @(posedge clk);
    #1;
    check(model, "R2 holds while tone idle");

    // Boundary pulses of the delay stage
    pulse(D_HI,     700, "R3 swallow at H=D_HI");
    pulse(D_HI + 1, 700, "R3 one cycle at H=D_HI+1");
    pulse(D_LO,     700, "R4 launch at H=D_LO");
    pulse(D_HI + 1, 700, "R3 back to low");
    pulse(D_LO + 2, 700, "R4 even count holds");
    pulse(120,      700, "R4 short pulse launches one cycle");
    pulse(H_1K,     700, "R5 odd count from high");

    // R6: directed tone switches in both directions
    run_tone(H_10K, 3, "R6 switch to 10kHz");
    run_tone(H_1K,  2, "R6 switch to 1kHz");
    run_tone(H_10K, 2, "R6 switch back to 10kHz");

    // Random tone segments with random phase (R5 R6 R8 R9)
    for (int s = 0; s < 8; s++) begin
      if ($urandom_range(1) == 1)
        run_tone(H_10K, 2 + $urandom_range(4), "R6 R5 R8 R9 random 10kHz");
      else
        run_tone(H_1K, 1 + $urandom_range(1), "R6 R5 R8 R9 random 1kHz");
      repeat ($urandom_range(200)) @(posedge clk);
    end

    // R1: asynchronous reset while output high
    run_tone(H_10K, 2, "R6 before reset");
    #3;
    rst_n = 1'b0;
    #1;
    check(1'b0, "R1 async clear mid-run");
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    model = 1'b0;
    repeat (20) @(posedge clk);
    #1;
    check(1'b0, "R1 low after mid-run release");

    report_end();
  end

endmodule